// File: doc/BRIEF.md
# Shift-Based EWMA Rate Smoother

This block keeps a running exponentially weighted average of aggregate bit-rate samples. Each time a new sample arrives with its valid strobe, the stored estimate moves toward the sample. A 3-bit weight code sets how far it moves, in steps of one eighth. The update uses only right shifts, shift-and-add multiplies by constants below eight, and one final adder. No general multiplier and no divider appear anywhere.

The weight code is read in the same cycle as the sample strobe. The updated estimate appears one clock later, together with a one-cycle output strobe. Between samples the estimate holds its value, and changes on the code or sample inputs have no effect. Each operand is shifted right before it is scaled, so the low bits that the shift drops are lost. A consumer that needs a bit-exact result must model this truncation in the same order.

Top module: `ewma_rate_smoother`

## Requirements
- R1: While reset is high, and on the first cycle after it, `estimate_o` is 0 and `out_valid_o` is 0.
- R2: `out_valid_o` is high in the cycle after a cycle with `in_valid_i` high, and is low in every other cycle.
- R3: With weight code 0 on `alpha_i`, the new estimate equals the sample. The previous estimate is ignored.
- R4: With an odd code k (1, 3, 5 or 7), the new estimate is k·(sample>>3) + (8−k)·(old>>3). The shift is applied before the multiply.
- R5: With code 2, the new estimate is (sample>>2) + 3·(old>>2). With code 6, it is 3·(sample>>2) + (old>>2).
- R6: With code 4, the new estimate is (sample>>1) + (old>>1).
- R7: In a cycle with `in_valid_i` low, the estimate does not change, whatever `sample_i` and `alpha_i` carry.
- R8: The first sample after reset is combined with a previous estimate of 0. No seeding is applied.
- R9: Only the value of `alpha_i` in the strobe cycle affects the result. Changes to it between samples have no effect on later updates.
- R10: A new estimate never exceeds the larger of the sample and the previous estimate, so the result never overflows DATA_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Sample strobe |
| sample_i | input | DATA_W | Aggregate rate sample |
| alpha_i | input | 3 | Weight code: 0 selects the sample alone, k = 1 to 7 gives the sample a weight of k/8 |
| out_valid_o | output | 1 | Pulses one cycle after each sample |
| estimate_o | output | DATA_W | Registered smoothed estimate |

## Verification
The bench builds the block with the default 32-bit sample width. The 3-bit weight code is fixed in the package, so all eight codes are driven. At 32 bits, all-ones samples and all-ones estimates are within reach. At that top of the range, multiplying before shifting would overflow, and the bound in R10 is at its tightest. Small odd values such as 7 and 15 show the low bits that each pre-shift drops. Back-to-back strobes, gapped strobes with the code changing in between, and a reset in the middle of a run exercise the timing and history rules.

// File: rtl/ewma_pkg.sv
package ewma_pkg;
  // Weight code width: the weight of a new sample is code / 2**ALPHA_W.
  localparam int unsigned ALPHA_W = 3;
  localparam int unsigned SHIFT_W = $clog2(ALPHA_W + 1);

  // Reduced shift/multiply form of one weight code.
  typedef struct packed {
    logic               bypass;  // code 0: take the sample unchanged
    logic [SHIFT_W-1:0] shift;   // common pre-shift of both operands
    logic [ALPHA_W-1:0] m_new;   // multiplier of the shifted sample
    logic [ALPHA_W-1:0] m_old;   // multiplier of the shifted history
  } weight_t;
endpackage

// File: rtl/ewma_weight_decode.sv
module ewma_weight_decode
  import ewma_pkg::*;
(
  input  logic [ALPHA_W-1:0] code_i,
  output weight_t            weight_o
);
  localparam logic [ALPHA_W:0] FULL = {1'b1, {ALPHA_W{1'b0}}};

  logic [SHIFT_W-1:0] tz;
  logic [ALPHA_W:0]   rest;

  // Remove the common power of two from code/FULL and (FULL-code)/FULL,
  // so that each operand is shifted as little as possible.
  always_comb begin
    tz = '0;
    for (int i = ALPHA_W - 1; i >= 0; i--) begin
      if (code_i[i]) tz = SHIFT_W'(i);
    end
    rest            = FULL - {1'b0, code_i};
    weight_o.bypass = (code_i == '0);
    weight_o.shift  = SHIFT_W'(ALPHA_W) - tz;
    weight_o.m_new  = code_i >> tz;
    weight_o.m_old  = ALPHA_W'(rest >> tz);
  end
endmodule

// File: rtl/ewma_scaled_term.sv
module ewma_scaled_term
  import ewma_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [DATA_W-1:0]  val_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [ALPHA_W-1:0] mult_i,
  output logic [DATA_W-1:0]  prod_o
);
  localparam int unsigned PW = DATA_W + ALPHA_W;

  logic [DATA_W-1:0] pre;
  logic [PW-1:0]     ext;
  logic [PW-1:0]     part [ALPHA_W];
  logic [PW-1:0]     acc;

  // Shift first, then multiply: the order fixes the truncation.
  assign pre = val_i >> shift_i;
  assign ext = {{ALPHA_W{1'b0}}, pre};

  for (genvar g = 0; g < ALPHA_W; g++) begin : g_part
    assign part[g] = mult_i[g] ? (ext << g) : '0;
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < ALPHA_W; i++) acc = acc + part[i];
  end

  assign prod_o = acc[DATA_W-1:0];

  // R10
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    acc[PW-1:DATA_W] == '0)
    else $error("scaled term exceeds DATA_W bits");
endmodule

// File: rtl/ewma_rate_smoother.sv
module ewma_rate_smoother
  import ewma_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               in_valid_i,
  input  logic [DATA_W-1:0]  sample_i,
  input  logic [ALPHA_W-1:0] alpha_i,
  output logic               out_valid_o,
  output logic [DATA_W-1:0]  estimate_o
);
  weight_t           w;
  logic [DATA_W-1:0] p_new, p_old;
  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] est_next;
  logic [DATA_W-1:0] est_q;
  logic              vld_q;

  ewma_weight_decode u_dec (
    .code_i   (alpha_i),
    .weight_o (w)
  );

  ewma_scaled_term #(.DATA_W(DATA_W)) u_new (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .val_i   (sample_i),
    .shift_i (w.shift),
    .mult_i  (w.m_new),
    .prod_o  (p_new)
  );

  ewma_scaled_term #(.DATA_W(DATA_W)) u_old (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .val_i   (est_q),
    .shift_i (w.shift),
    .mult_i  (w.m_old),
    .prod_o  (p_old)
  );

  assign sum      = {1'b0, p_new} + {1'b0, p_old};
  assign est_next = w.bypass ? sample_i : sum[DATA_W-1:0];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      est_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid_i;
      if (in_valid_i) est_q <= est_next;
    end
  end

  assign estimate_o  = est_q;
  assign out_valid_o = vld_q;

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    rst_i |=> (!out_valid_o && estimate_o == '0))
    else $error("state not cleared by reset");

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    in_valid_i |=> out_valid_o)
    else $error("missing output strobe");

  // R2
  valid_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !in_valid_i |=> !out_valid_o)
    else $error("spurious output strobe");

  // R3
  bypass_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_valid_i && alpha_i == '0) |=> estimate_o == $past(sample_i))
    else $error("code 0 did not pass the sample through");

  // R4
  weights_sum_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (in_valid_i && !w.bypass) |->
      ((ALPHA_W+1)'(w.m_new) + (ALPHA_W+1)'(w.m_old)) == ((ALPHA_W+1)'(1) << w.shift))
    else $error("decoded weights do not sum to one");

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !in_valid_i |=> $stable(estimate_o))
    else $error("estimate moved without a sample");

  // R10
  bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    in_valid_i |=> (estimate_o <= $past(sample_i) || estimate_o <= $past(est_q)))
    else $error("estimate above both operands");

  // R10
  sum_width_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    in_valid_i |-> !sum[DATA_W])
    else $error("final sum overflowed");
endmodule

// File: tb/ewma_rate_smoother_tb.sv
module ewma_rate_smoother_tb_top;
  localparam int unsigned DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] sample = '0;
  logic [2:0]    alpha = '0;
  logic          out_valid;
  logic [DW-1:0] estimate;

  int unsigned n_checks = 0;
  int unsigned n_fail = 0;
  int          cyc = 0;
  bit          done = 1'b0;
  longint unsigned model_e = 0;

  logic [DW-1:0] exp_q[$];
  int            stamp_q[$];
  string         tag_q[$];

  always #2 clk = ~clk;  // 250 MHz

  always @(posedge clk) cyc <= cyc + 1;

  ewma_rate_smoother #(.DATA_W(DW)) dut_i (
    .clk_i       (clk),
    .rst_i       (rst),
    .in_valid_i  (in_valid),
    .sample_i    (sample),
    .alpha_i     (alpha),
    .out_valid_o (out_valid),
    .estimate_o  (estimate)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint unsigned act, input longint unsigned exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Reference from the written rules, truncating each operand before scaling.
  function automatic longint unsigned ref_ewma(input int code, input longint unsigned s,
                                               input longint unsigned e);
    case (code)
      0: return s;
      1: return (s >> 3) + 7 * (e >> 3);
      2: return (s >> 2) + 3 * (e >> 2);
      3: return 3 * (s >> 3) + 5 * (e >> 3);
      4: return (s >> 1) + (e >> 1);
      5: return 5 * (s >> 3) + 3 * (e >> 3);
      6: return 3 * (s >> 2) + (e >> 2);
      default: return 7 * (s >> 3) + (e >> 3);
    endcase
  endfunction

  function automatic string tag_of(input int code);
    if (code == 0) return "R3";
    if (code == 4) return "R6";
    if (code == 2 || code == 6) return "R5";
    return "R4";
  endfunction

  // Driver: presents one sample and queues the expected result.
  task automatic send(input longint unsigned s, input int code);
    @(negedge clk);
    in_valid = 1'b1;
    sample   = DW'(s);
    alpha    = 3'(code);
    model_e  = ref_ewma(code, s, model_e) & 64'hFFFF_FFFF;
    exp_q.push_back(DW'(model_e));
    stamp_q.push_back(cyc);
    tag_q.push_back(tag_of(code));
  endtask

  // Idle cycles with noise on the ignored inputs.
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      sample   = $urandom;
      alpha    = 3'($urandom);
    end
  endtask

  // Monitor: pops and compares each produced result.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "strobe with nothing pending", 1, 0);
      end else begin
        logic [DW-1:0] e;
        int            st;
        string         tg;
        e  = exp_q.pop_front();
        st = stamp_q.pop_front();
        tg = tag_q.pop_front();
        check(cyc == st + 1, "R2", "strobe latency", longint'(cyc - st), 1);
        check(estimate == e, tg, "estimate", estimate, e);
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    // R1: cleared during reset
    check(estimate == '0, "R1", "estimate in reset", estimate, 0);
    check(!out_valid, "R1", "strobe in reset", out_valid, 0);
    rst = 1'b0;
    model_e = 0;
    @(negedge clk);
    // R1: still clear on the first cycle after reset
    check(estimate == '0, "R1", "estimate after reset", estimate, 0);
    check(!out_valid, "R1", "strobe after reset", out_valid, 0);
  endtask

  initial begin
    do_reset();

    // R8: first sample combines with a zero history: 3*(80>>3) = 30
    send(80, 3);
    idle(1);
    check(estimate == 30, "R8", "first sample, code 3", estimate, 30);

    // R4/R5/R6: every code, back to back
    for (int c = 0; c < 8; c++) send(1000 + 37 * c, c);
    idle(2);

    // Truncation order: odd small values lose the shifted-out bits
    send(7, 0);
    send(7, 4);   // R6: 3 + 3 = 6
    send(15, 1);  // R4: 1 + 7*0 = 1
    send(31, 6);  // R5
    idle(2);

    // R10: top of the range for every code
    for (int c = 1; c < 8; c++) begin
      send(64'hFFFF_FFFF, 0);
      send(64'hFFFF_FFFF, c);
    end
    send(0, 7);
    send(64'hFFFF_FFFF, 2);
    idle(2);

    // R7/R9: noise on ignored inputs between samples
    send(1000, 0);
    idle(6);
    check(estimate == 1000, "R7", "held across idle cycles", estimate, 1000);
    check(!out_valid, "R7", "no strobe while idle", out_valid, 0);
    send(0, 4);  // R9: only this cycle's code counts -> 500
    idle(1);
    check(estimate == 500, "R9", "code taken at strobe", estimate, 500);
    idle(3);

    // Random mixture of gaps and codes
    for (int i = 0; i < 300; i++) begin
      send(($urandom % 4 == 0) ? 64'hFFFF_FFFF : longint'($urandom), int'($urandom % 8));
      if ($urandom % 3 == 0) idle(1 + int'($urandom % 3));
    end
    idle(3);

    // R1/R8: reset in mid run clears history
    send(5000, 0);
    idle(2);
    do_reset();
    send(4000, 1);  // R8: 500 + 0
    idle(1);
    check(estimate == 500, "R8", "history cleared by reset", estimate, 500);
    idle(3);

    check(exp_q.size() == 0, "R2", "results still pending", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R2", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule